// File: doc/BRIEF.md
# Secure Memory Region Firewall

This block decides, for every memory access presented to it, whether the access may proceed. Software sets up to sixteen protected windows through a small 32-bit register port. Each window is described by a first and a last megabyte number, and each window has its own enable bit. An access marked non-secure is refused when its megabyte number lands inside any enabled window. An access marked secure is never refused.

Accesses enter on a valid/ready channel. Decisions leave on a second valid/ready channel, one cycle after acceptance. The channel has a single output stage. While a decision waits and its consumer holds `dec_ready` low, the block drops `acc_ready`, and the stored decision stays unchanged until it is taken.

Every refusal raises `viol_pulse` for one cycle. The refused address is kept in a register that software can read but not write. The block does not shape bus error responses or routing; its output is only the allow/deny bit and the pulse.

Top module: `sec_region_fw`

## Requirements
- R1: After reset, every window descriptor reads 0, the enable register reads 0, the violation address reads 0, and a non-secure access to any address is allowed.
- R2: The descriptor for window i is at register offset i*4. Bits 30:16 hold the last covered megabyte number and bits 14:0 hold the first. Bits 31 and 15 read as 0. Read data appears on `reg_rdata` the cycle after `reg_rd_en`.
- R3: The enable register is at offset 0xF0, and bit n enables window n. Bits at or above the window count read as 0.
- R4: A window whose enable bit is clear has no effect on decisions, whatever its descriptor holds.
- R5: An access falls in window n when first_n <= m <= last_n, where m is access address bits 31:20. Both ends are inclusive, and the megabyte just beyond either end is outside.
- R6: A non-secure access that falls in an enabled window is refused (`dec_allow`=0). For that access, `viol_pulse` is 1 in the first cycle its decision is valid, and its address becomes readable at offset 0xF4.
- R7: A secure access (`acc_secure`=1) is always allowed and never raises `viol_pulse`.
- R8: A decision is valid the cycle after its access is accepted. A register write changes only the decisions for accesses accepted after the write's clock edge; an access accepted on the same edge as the write sees the old settings.
- R9: While `dec_valid`=1 and `dec_ready`=0, `dec_valid` and `dec_allow` hold, `acc_ready` is 0, and no new access is taken.
- R10: Writes to offset 0xF4 or to unmapped offsets change nothing. Reads of unmapped offsets return 0.
- R11: When enabled windows overlap, an access is refused if any one of them covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after strobe |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request can be taken |
| acc_addr | input | ADDR_W | Access address |
| acc_secure | input | 1 | Access comes from the secure world |
| dec_valid | output | 1 | Decision valid |
| dec_ready | input | 1 | Consumer takes decision |
| dec_allow | output | 1 | 1 = access allowed, 0 = refused |
| viol_pulse | output | 1 | One-cycle flag marking a refused access |

## Verification
The bench checks both ends of a window, plus the megabyte just below and just above it. A compare that is off by one, or exclusive at one end, would refuse a neighbouring megabyte or let an edge megabyte through. It writes an enable bit on the same edge an access is accepted, so a design that forwards register writes combinationally would refuse that access too early. It stalls the decision channel with a refusal pending. This catches a stage that overwrites the held decision, keeps taking accesses, or repeats the violation pulse. It also tests overlapping windows, out-of-range descriptor bits and writes to the read-only register, which expose OR-reduction mistakes and loose address decoding.

// File: rtl/secfw_pkg.sv
package secfw_pkg;
  // width of a megabyte number in a window descriptor
  localparam int MB_W     = 15;
  // address bit where the megabyte number begins
  localparam int MB_SHIFT = 20;
  // descriptor field positions
  localparam int LAST_LSB  = 16;
  localparam int FIRST_LSB = 0;
  // fixed register offsets
  localparam logic [7:0] ENABLE_OFS = 8'hF0;
  localparam logic [7:0] VADDR_OFS  = 8'hF4;

  typedef struct packed {
    logic [MB_W-1:0] last_mb;
    logic [MB_W-1:0] first_mb;
  } window_t;

  function automatic logic [31:0] window_to_word(window_t w);
    logic [31:0] word;
    word = '0;
    word[LAST_LSB +: MB_W]  = w.last_mb;
    word[FIRST_LSB +: MB_W] = w.first_mb;
    return word;
  endfunction

  function automatic window_t word_to_window(logic [31:0] word);
    window_t w;
    w.last_mb  = word[LAST_LSB +: MB_W];
    w.first_mb = word[FIRST_LSB +: MB_W];
    return w;
  endfunction
endpackage

// File: rtl/secfw_regs.sv
module secfw_regs
  import secfw_pkg::*;
#(
  parameter int NWIN   = 16,
  parameter int ADDR_W = 32,
  parameter int RA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [RA_W-1:0]      addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [ADDR_W-1:0]    viol_addr,
  output window_t [NWIN-1:0]   windows,
  output logic [NWIN-1:0]      enables
);
  localparam logic [RA_W-1:0] EN_OFS = RA_W'(ENABLE_OFS);
  localparam logic [RA_W-1:0] VA_OFS = RA_W'(VADDR_OFS);

  logic [NWIN-1:0] win_sel;
  logic [31:0]     rd_mux;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    assign win_sel[g] = (addr == RA_W'(g * 4));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        windows[g] <= '0;
      end else if (wr_en && win_sel[g]) begin
        windows[g] <= word_to_window(wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enables <= '0;
    end else if (wr_en && addr == EN_OFS) begin
      enables <= wdata[NWIN-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win_sel[i]) rd_mux = window_to_word(windows[i]);
    end
    if (addr == EN_OFS) rd_mux = 32'(enables);
    if (addr == VA_OFS) rd_mux = 32'(viol_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/secfw_match.sv
module secfw_match
  import secfw_pkg::*;
#(
  parameter int NWIN   = 16,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr,
  input  window_t [NWIN-1:0] windows,
  input  logic [NWIN-1:0]    enables,
  output logic [NWIN-1:0]    hit
);
  localparam int ADDR_MB_W = ADDR_W - MB_SHIFT;

  logic [ADDR_MB_W-1:0] addr_mb;
  logic [MB_W-1:0]      mb;

  assign addr_mb = addr[ADDR_W-1:MB_SHIFT];
  assign mb      = MB_W'(addr_mb);

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    logic above_first;
    logic below_last;
    assign above_first = (mb >= windows[g].first_mb);
    assign below_last  = (mb <= windows[g].last_mb);
    assign hit[g]      = enables[g] && above_first && below_last;
  end
endmodule

// File: rtl/secfw_decide.sv
module secfw_decide #(
  parameter int NWIN   = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  input  logic [NWIN-1:0]   hit,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_allow,
  output logic              viol_pulse,
  output logic [ADDR_W-1:0] viol_addr
);
  logic take;
  logic refuse;

  assign acc_ready = !dec_valid || dec_ready;
  assign take      = acc_valid && acc_ready;
  assign refuse    = !acc_secure && (|hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_allow  <= 1'b0;
      viol_pulse <= 1'b0;
      viol_addr  <= '0;
    end else begin
      viol_pulse <= take && refuse;
      if (take) begin
        dec_valid <= 1'b1;
        dec_allow <= !refuse;
        if (refuse) viol_addr <= acc_addr;
      end else if (dec_ready) begin
        dec_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_region_fw.sv
module sec_region_fw
  import secfw_pkg::*;
#(
  parameter int NWIN   = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  output logic              dec_valid,
  input  logic              dec_ready,
  output logic              dec_allow,
  output logic              viol_pulse
);
  window_t [NWIN-1:0] windows;
  logic [NWIN-1:0]    enables;
  logic [NWIN-1:0]    hit;
  logic [ADDR_W-1:0]  viol_addr;

  secfw_regs #(.NWIN(NWIN), .ADDR_W(ADDR_W), .RA_W(8)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .viol_addr (viol_addr),
    .windows   (windows),
    .enables   (enables)
  );

  secfw_match #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_match (
    .addr    (acc_addr),
    .windows (windows),
    .enables (enables),
    .hit     (hit)
  );

  secfw_decide #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_ready  (acc_ready),
    .acc_addr   (acc_addr),
    .acc_secure (acc_secure),
    .hit        (hit),
    .dec_valid  (dec_valid),
    .dec_ready  (dec_ready),
    .dec_allow  (dec_allow),
    .viol_pulse (viol_pulse),
    .viol_addr  (viol_addr)
  );
endmodule

// File: rtl/secfw_checker.sv
module secfw_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_valid,
  input logic acc_ready,
  input logic acc_secure,
  input logic dec_valid,
  input logic dec_ready,
  input logic dec_allow,
  input logic viol_pulse
);
  logic sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sec_q <= 1'b0;
    else if (acc_valid && acc_ready) sec_q <= acc_secure;
  end

  AST_VIOL_MEANS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (dec_valid && !dec_allow)); // R6

  AST_VIOL_FROM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> $past(acc_valid && acc_ready && !acc_secure)); // R6

  AST_SECURE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && sec_q) |-> (dec_allow && !viol_pulse)); // R7

  AST_NEW_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(acc_valid && acc_ready)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_allow))); // R9
endmodule

bind sec_region_fw secfw_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_secure (acc_secure),
  .dec_valid  (dec_valid),
  .dec_ready  (dec_ready),
  .dec_allow  (dec_allow),
  .viol_pulse (viol_pulse)
);

// File: tb/sec_region_fw_test.sv
`timescale 1ns/1ps
module sec_region_fw_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic        acc_secure = 1'b0;
  logic        dec_valid;
  logic        dec_ready = 1'b1;
  logic        dec_allow;
  logic        viol_pulse;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_viol = '0;

  always #2.5 clk = ~clk;

  sec_region_fw uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_secure(acc_secure), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_allow(dec_allow), .viol_pulse(viol_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd_check(input logic [7:0] a, input logic [31:0] exp,
                              input string req);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(reg_rdata === exp, req, reg_rdata, exp);
  endtask

  // one access with the decision channel free; checks the decision and pulse
  task automatic access(input logic [31:0] a, input logic sec,
                        input logic exp_allow, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_secure = sec;
    @(negedge clk);
    acc_valid = 1'b0;
    check(dec_valid === 1'b1, {req, " valid"}, 32'(dec_valid), 32'd1);
    check(dec_allow === exp_allow, {req, " allow"}, 32'(dec_allow), 32'(exp_allow));
    check(viol_pulse === !exp_allow, {req, " pulse"}, 32'(viol_pulse), 32'(!exp_allow));
    if (!exp_allow) last_viol = a;
  endtask

  task automatic t_reset();
    reg_rd_check(8'h00, 32'h0, "R1 desc0");
    reg_rd_check(8'h3C, 32'h0, "R1 desc15");
    reg_rd_check(8'hF0, 32'h0, "R1 enables");
    reg_rd_check(8'hF4, 32'h0, "R1 viol addr");
    access(32'h0000_0000, 1'b0, 1'b1, "R1 ns access after reset");
  endtask

  task automatic t_readback();
    reg_wr(8'h0C, 32'hFFFF_FFFF);
    reg_rd_check(8'h0C, 32'h7FFF_7FFF, "R2 desc3 field masking");
    reg_wr(8'h0C, 32'h0);
    reg_wr(8'hF0, 32'hFFFF_FFFF);
    reg_rd_check(8'hF0, 32'h0000_FFFF, "R3 enable width");
    reg_wr(8'hF0, 32'h0);
  endtask

  task automatic t_disabled();
    reg_wr(8'h08, 32'h001F_0010);
    reg_rd_check(8'h08, 32'h001F_0010, "R2 desc2 readback");
    access(32'h0150_0000, 1'b0, 1'b1, "R4 disabled window");
  endtask

  task automatic t_bounds();
    // write enable and present an access on the same edge: old settings apply
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'hF0; reg_wdata = 32'h0000_0004;
    acc_valid = 1'b1; acc_addr = 32'h0150_0000; acc_secure = 1'b0;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0;
    check(dec_allow === 1'b1, "R8 same-edge write not seen", 32'(dec_allow), 32'd1);
    access(32'h0150_0000, 1'b0, 1'b0, "R8 write seen next cycle");
    access(32'h0100_0000, 1'b0, 1'b0, "R5 first mb inclusive");
    reg_rd_check(8'hF4, 32'h0100_0000, "R6 viol addr captured");
    check(viol_pulse === 1'b0, "R6 pulse one cycle", 32'(viol_pulse), 32'd0);
    access(32'h01FF_FFFF, 1'b0, 1'b0, "R5 last mb inclusive");
    access(32'h00FF_FFFF, 1'b0, 1'b1, "R5 below first mb");
    access(32'h0200_0000, 1'b0, 1'b1, "R5 above last mb");
  endtask

  task automatic t_secure();
    access(32'h0150_0000, 1'b1, 1'b1, "R7 secure passes");
    access(32'h0100_0000, 1'b1, 1'b1, "R7 secure at edge");
  endtask

  task automatic t_stall();
    @(negedge clk);
    dec_ready = 1'b0;
    acc_valid = 1'b1; acc_addr = 32'h01FF_FFFF; acc_secure = 1'b0;
    @(negedge clk);
    last_viol = 32'h01FF_FFFF;
    check(dec_valid === 1'b1 && dec_allow === 1'b0, "R9 refused decision",
          {30'd0, dec_valid, dec_allow}, 32'd2);
    check(viol_pulse === 1'b1, "R6 pulse on stalled refusal", 32'(viol_pulse), 32'd1);
    acc_addr = 32'h0200_0000;
    check(acc_ready === 1'b0, "R9 ready low while stalled", 32'(acc_ready), 32'd0);
    @(negedge clk);
    check(dec_valid === 1'b1 && dec_allow === 1'b0, "R9 decision held",
          {30'd0, dec_valid, dec_allow}, 32'd2);
    check(viol_pulse === 1'b0, "R9 no repeated pulse", 32'(viol_pulse), 32'd0);
    check(acc_ready === 1'b0, "R9 still blocked", 32'(acc_ready), 32'd0);
    dec_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check(dec_valid === 1'b1 && dec_allow === 1'b1, "R9 next decision after release",
          {30'd0, dec_valid, dec_allow}, 32'd3);
    @(negedge clk);
    check(dec_valid === 1'b0, "R9 channel drains", 32'(dec_valid), 32'd0);
  endtask

  task automatic t_overlap();
    reg_wr(8'h3C, 32'h0800_0010);
    reg_wr(8'hF0, 32'h0000_8004);
    access(32'h0150_0000, 1'b0, 1'b0, "R11 both windows");
    reg_wr(8'hF0, 32'h0000_8000);
    access(32'h0150_0000, 1'b0, 1'b0, "R11 outer window alone");
    access(32'h8000_0000, 1'b0, 1'b0, "R5 window15 last mb");
    access(32'h8010_0000, 1'b0, 1'b1, "R5 window15 past last");
    reg_wr(8'hF0, 32'h0000_0004);
    access(32'h8000_0000, 1'b0, 1'b1, "R4 window15 disabled");
  endtask

  task automatic t_ignored();
    reg_wr(8'hF4, 32'h1234_5678);
    reg_rd_check(8'hF4, last_viol, "R10 viol addr read-only");
    reg_wr(8'h40, 32'hFFFF_FFFF);
    reg_wr(8'h80, 32'hFFFF_FFFF);
    reg_rd_check(8'h40, 32'h0, "R10 unmapped 0x40 reads 0");
    reg_rd_check(8'h80, 32'h0, "R10 unmapped 0x80 reads 0");
    reg_rd_check(8'hF0, 32'h0000_0004, "R10 enables unchanged");
    reg_rd_check(8'h08, 32'h001F_0010, "R10 desc2 unchanged");
    access(32'h0300_0000, 1'b0, 1'b1, "R10 no new window");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(dec_valid === 1'b0 && viol_pulse === 1'b0, "R1 outputs idle",
          {30'd0, dec_valid, viol_pulse}, 32'd0);
    t_reset();
    t_readback();
    t_disabled();
    t_bounds();
    t_secure();
    t_stall();
    t_overlap();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule